// File: doc/BRIEF.md
# Cache Reconfiguration Sequencer

This block walks a processor core through a safe change of its memory-type range settings. One pulse on `start_i` runs three phases. The prepare phase puts the cache into no-fill mode and flushes it. It turns off global page translations and flushes the TLB. It then disables range typing by zeroing the type fields of the default-type register, which forces the default to uncacheable. The program phase writes `NUM_WR` new configuration words, each an address and data pair, in index order. The restore phase flushes the TLB and puts back the saved default-type value. It then leaves no-fill mode and puts back the extended control register.

Every register access goes through one request port: request, write enable, address, write data, read data and a done strobe. The request stays up until done arrives. Cache flushes and TLB flushes each have their own request and acknowledge pair. Two capability inputs are sampled when the sequence starts. `self_snoop_i` removes both cache flushes. `page_global_i` enables the save, clear and restore of the extended control register.

Top module: `cache_reconfig_seq`

## Requirements
- R1: While reset is held, and whenever the sequencer is idle, `busy_o`, `done_o` and all three request outputs are 0.
- R2: A `start_i` pulse seen while idle makes `busy_o` 1 from the next cycle. `done_o` is 1 for exactly one cycle, which is the last cycle in which `busy_o` is 1.
- R3: The sequence first reads the main control register at `ADDR_CTL`. It then writes back that value with bit `CD_BIT` (30) set and bit `NW_BIT` (29) cleared, keeping all other bits.
- R4: A cache flush follows the no-fill write, and a second cache flush follows the default-type disable write. Both are left out when `self_snoop_i` was 1 at start.
- R5: When `page_global_i` was 1 at start, the extended control register at `ADDR_EXT` is read and then written with bit `PGE_BIT` (7) cleared. The saved value is written back as the very last access. When it was 0, `ADDR_EXT` is never accessed.
- R6: One TLB flush comes after the extended-register step, or after the no-fill step when that step is absent, and before the default-type read.
- R7: The default-type register at `ADDR_DEF` is read and then written with bits 11:10 and 7:0 cleared (mask 0xCFF). All other bits are kept.
- R8: After the prepare phase, exactly `NUM_WR` writes are issued in index order 0 up to `NUM_WR-1`. Entry i uses `cfg_addr_i[i]` and `cfg_data_i[i]`.
- R9: The restore phase runs in this order: a TLB flush, a write of the saved default-type value, a fresh read of the control register, and a write of that value with bit 30 cleared. It issues no cache flush.
- R10: Only one request is raised at a time. A raised register request keeps its address, write enable and write data stable until `creg_done_i`. A raised flush request stays up until its acknowledge.
- R11: A `start_i` pulse that arrives while busy is ignored. It neither restarts nor repeats the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a reconfiguration sequence |
| self_snoop_i | input | 1 | Cache self-snoop capability; skips cache flushes |
| page_global_i | input | 1 | Global-page capability; enables the extended-register step |
| cfg_addr_i | input | NUM_WR x AW | Register addresses of the new configuration words |
| cfg_data_i | input | NUM_WR x DW | Values of the new configuration words |
| creg_req_o | output | 1 | Register access request |
| creg_we_o | output | 1 | 1 = write, 0 = read |
| creg_addr_o | output | AW | Register address |
| creg_wdata_o | output | DW | Write data |
| creg_rdata_i | input | DW | Read data, valid with done |
| creg_done_i | input | 1 | Access complete |
| cflush_req_o | output | 1 | Cache write-back-and-invalidate request |
| cflush_ack_i | input | 1 | Cache flush complete |
| tflush_req_o | output | 1 | Local TLB flush request |
| tflush_ack_i | input | 1 | TLB flush complete |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong state shows up at the ports as an access out of place in the transaction order. It can appear as a missing flush, an extra flush, an access to the extended register when the capability is off, or a write whose data does not follow from the last value read. Each such error is visible at the next request edge after the faulty transition, so at most one handshake later. A wrong saved word shows up later, in the restore writes, as a final register value that differs from the starting value. A stuck state shows up as `done_o` never rising.

State names are IDLE, CTL_RD, CTL_NOFILL, CFLUSH_A, EXT_RD, EXT_PGOFF, TFLUSH_A, DEF_RD, DEF_OFF, CFLUSH_B, CFG_WR, TFLUSH_B, DEF_BACK, CTL_RD2, CTL_FILL, EXT_BACK and FIN. They advance on the done or acknowledge of their own request. Only IDLE moves on `start_i`, and FIN moves on its own to IDLE. CTL_NOFILL goes to CFLUSH_A, EXT_RD or TFLUSH_A depending on the two captured capabilities. DEF_OFF goes to CFLUSH_B or CFG_WR. CFG_WR repeats until the last index. CTL_FILL goes to EXT_BACK or FIN.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_CTL_RD,
        S_CTL_NOFILL,
        S_CFLUSH_A,
        S_EXT_RD,
        S_EXT_PGOFF,
        S_TFLUSH_A,
        S_DEF_RD,
        S_DEF_OFF,
        S_CFLUSH_B,
        S_CFG_WR,
        S_TFLUSH_B,
        S_DEF_BACK,
        S_CTL_RD2,
        S_CTL_FILL,
        S_EXT_BACK,
        S_FIN
    } crs_state_t;

    typedef enum logic [1:0] {
        SLOT_CTL = 2'd0,
        SLOT_EXT = 2'd1,
        SLOT_DEF = 2'd2
    } crs_slot_t;

    localparam int NSLOT = 3;

    // type fields of the default-type register: enables 11:10, default 7:0
    localparam logic [11:0] DEF_TYPE_FIELDS = 12'hCFF;

endpackage

// File: rtl/crs_save_bank.sv
module crs_save_bank
    import crs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en,
    input  crs_slot_t                   cap_sel,
    input  logic [DW-1:0]               rdata,
    output logic [NSLOT-1:0][DW-1:0]    words
);

    logic [NSLOT-1:0][DW-1:0] slot_q;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (cap_en && (int'(cap_sel) == g)) begin
                slot_q[g] <= rdata;
            end
        end
    end

    assign words = slot_q;

endmodule

// File: rtl/crs_cfg_index.sv
module crs_cfg_index #(
    parameter int NUM_WR = 4,
    localparam int IW = (NUM_WR > 1) ? $clog2(NUM_WR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          last
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WR - 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (adv && (idx_q != LAST_IDX)) begin
            idx_q <= idx_q + IW'(1);
        end
    end

    assign idx  = idx_q;
    assign last = (idx_q == LAST_IDX);

endmodule

// File: rtl/crs_wdata_mux.sv
module crs_wdata_mux
    import crs_pkg::*;
#(
    parameter int DW      = 32,
    parameter int CD_BIT  = 30,
    parameter int NW_BIT  = 29,
    parameter int PGE_BIT = 7
) (
    input  crs_state_t                  state,
    input  logic [NSLOT-1:0][DW-1:0]    saved,
    input  logic [DW-1:0]               cfg_word,
    output logic [DW-1:0]               wdata
);

    localparam logic [DW-1:0] CD_M  = DW'(1) << CD_BIT;
    localparam logic [DW-1:0] NW_M  = DW'(1) << NW_BIT;
    localparam logic [DW-1:0] PGE_M = DW'(1) << PGE_BIT;
    localparam logic [DW-1:0] DEF_M = DW'(DEF_TYPE_FIELDS);

    logic [DW-1:0] ctl_w, ext_w, def_w;

    assign ctl_w = saved[SLOT_CTL];
    assign ext_w = saved[SLOT_EXT];
    assign def_w = saved[SLOT_DEF];

    always_comb begin
        wdata = '0;
        unique case (state)
            S_CTL_NOFILL: wdata = (ctl_w | CD_M) & ~NW_M;
            S_EXT_PGOFF:  wdata = ext_w & ~PGE_M;
            S_DEF_OFF:    wdata = def_w & ~DEF_M;
            S_CFG_WR:     wdata = cfg_word;
            S_DEF_BACK:   wdata = def_w;
            S_CTL_FILL:   wdata = ctl_w & ~CD_M;
            S_EXT_BACK:   wdata = ext_w;
            default:      wdata = '0;
        endcase
    end

endmodule

// File: rtl/cache_reconfig_seq.sv
module cache_reconfig_seq
    import crs_pkg::*;
#(
    parameter int              AW       = 12,
    parameter int              DW       = 32,
    parameter int              NUM_WR   = 4,
    parameter logic [AW-1:0]   ADDR_CTL = 12'h000,
    parameter logic [AW-1:0]   ADDR_EXT = 12'h004,
    parameter logic [AW-1:0]   ADDR_DEF = 12'h2FF,
    parameter int              CD_BIT   = 30,
    parameter int              NW_BIT   = 29,
    parameter int              PGE_BIT  = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         self_snoop_i,
    input  logic                         page_global_i,
    input  logic [NUM_WR-1:0][AW-1:0]    cfg_addr_i,
    input  logic [NUM_WR-1:0][DW-1:0]    cfg_data_i,
    output logic                         creg_req_o,
    output logic                         creg_we_o,
    output logic [AW-1:0]                creg_addr_o,
    output logic [DW-1:0]                creg_wdata_o,
    input  logic [DW-1:0]                creg_rdata_i,
    input  logic                         creg_done_i,
    output logic                         cflush_req_o,
    input  logic                         cflush_ack_i,
    output logic                         tflush_req_o,
    input  logic                         tflush_ack_i,
    output logic                         busy_o,
    output logic                         done_o
);

    localparam int IW = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;

    crs_state_t state_q, state_d;
    logic       snoop_q, pg_q;
    logic [IW-1:0] idx;
    logic       idx_last;
    logic       cap_en;
    crs_slot_t  cap_sel;
    logic [NSLOT-1:0][DW-1:0] saved;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // capabilities are frozen for the whole run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snoop_q <= 1'b0;
            pg_q    <= 1'b0;
        end else if (state_q == S_IDLE && start_i) begin
            snoop_q <= self_snoop_i;
            pg_q    <= page_global_i;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start_i)      state_d = S_CTL_RD;
            S_CTL_RD:     if (creg_done_i)  state_d = S_CTL_NOFILL;
            S_CTL_NOFILL: if (creg_done_i) begin
                              if (!snoop_q)  state_d = S_CFLUSH_A;
                              else if (pg_q) state_d = S_EXT_RD;
                              else           state_d = S_TFLUSH_A;
                          end
            S_CFLUSH_A:   if (cflush_ack_i) state_d = pg_q ? S_EXT_RD : S_TFLUSH_A;
            S_EXT_RD:     if (creg_done_i)  state_d = S_EXT_PGOFF;
            S_EXT_PGOFF:  if (creg_done_i)  state_d = S_TFLUSH_A;
            S_TFLUSH_A:   if (tflush_ack_i) state_d = S_DEF_RD;
            S_DEF_RD:     if (creg_done_i)  state_d = S_DEF_OFF;
            S_DEF_OFF:    if (creg_done_i)  state_d = snoop_q ? S_CFG_WR : S_CFLUSH_B;
            S_CFLUSH_B:   if (cflush_ack_i) state_d = S_CFG_WR;
            S_CFG_WR:     if (creg_done_i && idx_last) state_d = S_TFLUSH_B;
            S_TFLUSH_B:   if (tflush_ack_i) state_d = S_DEF_BACK;
            S_DEF_BACK:   if (creg_done_i)  state_d = S_CTL_RD2;
            S_CTL_RD2:    if (creg_done_i)  state_d = S_CTL_FILL;
            S_CTL_FILL:   if (creg_done_i)  state_d = pg_q ? S_EXT_BACK : S_FIN;
            S_EXT_BACK:   if (creg_done_i)  state_d = S_FIN;
            S_FIN:                          state_d = S_IDLE;
            default:                        state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        creg_req_o   = 1'b0;
        creg_we_o    = 1'b0;
        creg_addr_o  = '0;
        cflush_req_o = 1'b0;
        tflush_req_o = 1'b0;
        done_o       = 1'b0;
        cap_en       = 1'b0;
        cap_sel      = SLOT_CTL;
        unique case (state_q)
            S_CTL_RD, S_CTL_RD2: begin
                creg_req_o  = 1'b1;
                creg_addr_o = ADDR_CTL;
                cap_en      = creg_done_i;
                cap_sel     = SLOT_CTL;
            end
            S_CTL_NOFILL, S_CTL_FILL: begin
                creg_req_o  = 1'b1;
                creg_we_o   = 1'b1;
                creg_addr_o = ADDR_CTL;
            end
            S_EXT_RD: begin
                creg_req_o  = 1'b1;
                creg_addr_o = ADDR_EXT;
                cap_en      = creg_done_i;
                cap_sel     = SLOT_EXT;
            end
            S_EXT_PGOFF, S_EXT_BACK: begin
                creg_req_o  = 1'b1;
                creg_we_o   = 1'b1;
                creg_addr_o = ADDR_EXT;
            end
            S_DEF_RD: begin
                creg_req_o  = 1'b1;
                creg_addr_o = ADDR_DEF;
                cap_en      = creg_done_i;
                cap_sel     = SLOT_DEF;
            end
            S_DEF_OFF, S_DEF_BACK: begin
                creg_req_o  = 1'b1;
                creg_we_o   = 1'b1;
                creg_addr_o = ADDR_DEF;
            end
            S_CFG_WR: begin
                creg_req_o  = 1'b1;
                creg_we_o   = 1'b1;
                creg_addr_o = cfg_addr_i[idx];
            end
            S_CFLUSH_A, S_CFLUSH_B: cflush_req_o = 1'b1;
            S_TFLUSH_A, S_TFLUSH_B: tflush_req_o = 1'b1;
            S_FIN:                  done_o       = 1'b1;
            default: ;
        endcase
    end

    assign busy_o = (state_q != S_IDLE);

    crs_save_bank #(.DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_sel (cap_sel),
        .rdata   (creg_rdata_i),
        .words   (saved)
    );

    crs_cfg_index #(.NUM_WR(NUM_WR)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == S_IDLE),
        .adv   ((state_q == S_CFG_WR) && creg_done_i),
        .idx   (idx),
        .last  (idx_last)
    );

    crs_wdata_mux #(
        .DW      (DW),
        .CD_BIT  (CD_BIT),
        .NW_BIT  (NW_BIT),
        .PGE_BIT (PGE_BIT)
    ) u_wmux (
        .state    (state_q),
        .saved    (saved),
        .cfg_word (cfg_data_i[idx]),
        .wdata    (creg_wdata_o)
    );

endmodule

// File: rtl/crs_chk.sv
module crs_chk #(
    parameter int            AW       = 12,
    parameter int            DW       = 32,
    parameter logic [AW-1:0] ADDR_EXT = 12'h004
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          creg_req_o,
    input logic          creg_we_o,
    input logic [AW-1:0] creg_addr_o,
    input logic [DW-1:0] creg_wdata_o,
    input logic          creg_done_i,
    input logic          cflush_req_o,
    input logic          cflush_ack_i,
    input logic          tflush_req_o,
    input logic          tflush_ack_i,
    input logic          snoop_q,
    input logic          pg_q
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(creg_req_o || cflush_req_o || tflush_req_o || done_o));

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_snoop_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cflush_req_o |-> !snoop_q);

    p_cflush_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cflush_req_o && !cflush_ack_i) |=> cflush_req_o);

    p_ext_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (creg_req_o && creg_addr_o == ADDR_EXT) |-> pg_q);

    p_tflush_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tflush_req_o && !tflush_ack_i) |=> tflush_req_o);

    p_single_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({creg_req_o, cflush_req_o, tflush_req_o}));

    p_creg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (creg_req_o && !creg_done_i) |=>
            (creg_req_o && $stable(creg_addr_o) && $stable(creg_we_o) && $stable(creg_wdata_o)));

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o) |=> busy_o);

endmodule

bind cache_reconfig_seq crs_chk #(.AW(AW), .DW(DW), .ADDR_EXT(ADDR_EXT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .creg_req_o   (creg_req_o),
    .creg_we_o    (creg_we_o),
    .creg_addr_o  (creg_addr_o),
    .creg_wdata_o (creg_wdata_o),
    .creg_done_i  (creg_done_i),
    .cflush_req_o (cflush_req_o),
    .cflush_ack_i (cflush_ack_i),
    .tflush_req_o (tflush_req_o),
    .tflush_ack_i (tflush_ack_i),
    .snoop_q      (snoop_q),
    .pg_q         (pg_q)
);

// File: tb/tb_cache_reconfig_seq.sv
module tb_cache_reconfig_seq;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NW = 4;
    localparam logic [AW-1:0] A_CTL = 12'h000;
    localparam logic [AW-1:0] A_EXT = 12'h004;
    localparam logic [AW-1:0] A_DEF = 12'h2FF;
    localparam logic [DW-1:0] CD = 32'h4000_0000;
    localparam logic [DW-1:0] NWT = 32'h2000_0000;

    logic clk, rst_n, start, snoop, pg;
    logic [NW-1:0][AW-1:0] cfg_addr;
    logic [NW-1:0][DW-1:0] cfg_data;
    logic creg_req, creg_we, creg_done;
    logic [AW-1:0] creg_addr;
    logic [DW-1:0] creg_wdata, creg_rdata;
    logic cflush_req, cflush_ack, tflush_req, tflush_ack, busy, done;

    int total = 0;
    int bad = 0;
    int lat = 0;

    // register model and transaction log (kind 0 rd, 1 wr, 2 cache flush, 3 tlb flush)
    logic [DW-1:0] m_ctl, m_ext, m_def;
    int lg_n;
    int lg_kind [64];
    logic [AW-1:0] lg_addr [64];
    logic [DW-1:0] lg_data [64];
    int ex_n;
    int ex_kind [64];
    logic [AW-1:0] ex_addr [64];
    logic [DW-1:0] ex_data [64];
    string ex_tag [64];

    cache_reconfig_seq #(.AW(AW), .DW(DW), .NUM_WR(NW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .self_snoop_i(snoop),
        .page_global_i(pg), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
        .creg_req_o(creg_req), .creg_we_o(creg_we), .creg_addr_o(creg_addr),
        .creg_wdata_o(creg_wdata), .creg_rdata_i(creg_rdata), .creg_done_i(creg_done),
        .cflush_req_o(cflush_req), .cflush_ack_i(cflush_ack),
        .tflush_req_o(tflush_req), .tflush_ack_i(tflush_ack),
        .busy_o(busy), .done_o(done)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // register port responder
    initial begin
        int cnt;
        cnt = 0;
        creg_done = 1'b0;
        creg_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst_n || creg_done) begin
                creg_done = 1'b0;
                cnt = 0;
            end else if (creg_req) begin
                if (cnt >= lat) begin
                    if (lg_n < 64) begin
                        lg_kind[lg_n] = creg_we ? 1 : 0;
                        lg_addr[lg_n] = creg_addr;
                    end
                    if (creg_we) begin
                        if (creg_addr == A_CTL) m_ctl = creg_wdata;
                        else if (creg_addr == A_EXT) m_ext = creg_wdata;
                        else if (creg_addr == A_DEF) m_def = creg_wdata;
                        if (lg_n < 64) lg_data[lg_n] = creg_wdata;
                    end else begin
                        if (creg_addr == A_CTL) creg_rdata = m_ctl;
                        else if (creg_addr == A_EXT) creg_rdata = m_ext;
                        else if (creg_addr == A_DEF) creg_rdata = m_def;
                        else creg_rdata = '0;
                        if (lg_n < 64) lg_data[lg_n] = creg_rdata;
                    end
                    lg_n++;
                    creg_done = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // flush responder
    initial begin
        int cnt;
        cnt = 0;
        cflush_ack = 1'b0;
        tflush_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n || cflush_ack || tflush_ack) begin
                cflush_ack = 1'b0;
                tflush_ack = 1'b0;
                cnt = 0;
            end else if (cflush_req || tflush_req) begin
                if (cnt >= lat) begin
                    if (lg_n < 64) begin
                        lg_kind[lg_n] = cflush_req ? 2 : 3;
                        lg_addr[lg_n] = '0;
                        lg_data[lg_n] = '0;
                    end
                    lg_n++;
                    if (cflush_req) cflush_ack = 1'b1;
                    else tflush_ack = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic push(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        ex_kind[ex_n] = k;
        ex_addr[ex_n] = a;
        ex_data[ex_n] = d;
        ex_tag[ex_n] = tag;
        ex_n++;
    endtask

    // expected order built from the requirements
    task automatic build_exp(input bit sn, input bit pgc, input logic [DW-1:0] c0,
                             input logic [DW-1:0] e0, input logic [DW-1:0] d0);
        logic [DW-1:0] nofill;
        nofill = (c0 | CD) & ~NWT;
        ex_n = 0;
        push(0, A_CTL, c0, "R3");
        push(1, A_CTL, nofill, "R3");
        if (!sn) push(2, '0, '0, "R4");
        if (pgc) begin
            push(0, A_EXT, e0, "R5");
            push(1, A_EXT, e0 & ~32'h80, "R5");
        end
        push(3, '0, '0, "R6");
        push(0, A_DEF, d0, "R7");
        push(1, A_DEF, d0 & ~32'hCFF, "R7");
        if (!sn) push(2, '0, '0, "R4");
        for (int i = 0; i < NW; i++) push(1, cfg_addr[i], cfg_data[i], "R8");
        push(3, '0, '0, "R9");
        push(1, A_DEF, d0, "R9");
        push(0, A_CTL, nofill, "R9");
        push(1, A_CTL, nofill & ~CD, "R9");
        if (pgc) push(1, A_EXT, e0, "R5");
    endtask

    task automatic run_seq(input bit sn, input bit pgc, input int l, input bit poke,
                           input logic [DW-1:0] c0, input logic [DW-1:0] e0, input logic [DW-1:0] d0);
        int waited;
        int n_after;
        bit seen;
        lat = l;
        m_ctl = c0;
        m_ext = e0;
        m_def = d0;
        lg_n = 0;
        @(negedge clk);
        snoop = sn;
        pg = pgc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        snoop = ~sn;
        pg = ~pgc;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        waited = 0;
        seen = 0;
        while (!seen && waited < 2000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 8) begin
                check(busy == 1'b1, "R11 busy when extra start", busy, 1);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                waited++;
            end
            if (done) seen = 1;
        end
        check(seen, "R2 done seen", seen, 1);
        check(busy == 1'b1, "R2 done in last busy cycle", busy, 1);
        @(negedge clk);
        check(!done && !busy, "R2 done one cycle", {done, busy}, 0);
        n_after = lg_n;
        repeat (6) @(negedge clk);
        check(!busy && lg_n == n_after, "R11 no restart", lg_n, n_after);
        build_exp(sn, pgc, c0, e0, d0);
        check(lg_n == ex_n, "R8 access count", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            check(lg_kind[i] == ex_kind[i] && lg_addr[i] == ex_addr[i] && lg_data[i] == ex_data[i],
                  ex_tag[i], {lg_kind[i][3:0], 4'h0, lg_addr[i], lg_data[i]},
                  {ex_kind[i][3:0], 4'h0, ex_addr[i], ex_data[i]});
        end
        check(m_def == d0, "R9 default type restored", m_def, d0);
        check(m_ext == e0, "R5 ext restored", m_ext, e0);
        check(m_ctl == (((c0 | CD) & ~NWT) & ~CD), "R9 control final", m_ctl, ((c0 | CD) & ~NWT) & ~CD);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        start = 1'b0;
        snoop = 1'b0;
        pg = 1'b0;
        lg_n = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !creg_req && !cflush_req && !tflush_req, "R1 reset outputs",
              {busy, done, creg_req, cflush_req, tflush_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !creg_req && !cflush_req && !tflush_req, "R1 idle outputs",
              {busy, creg_req, cflush_req, tflush_req}, 0);
    endtask

    // full prepare: flushes and global-page step present (R3 R4 R5 R6 R7 R8 R9)
    task automatic t_full;
        run_seq(1'b0, 1'b1, 1, 1'b0, 32'h2000_0033, 32'h0000_06F0, 32'h0000_3C06);
    endtask

    // self-snoop, no global pages: no flush of the cache, no extended access (R4 R5)
    task automatic t_snoop_nopg;
        run_seq(1'b1, 1'b0, 3, 1'b0, 32'h8000_0011, 32'h0000_0080, 32'h0001_0C1E);
    endtask

    // zero latency, flushes on, no global pages (R4 R6 R10)
    task automatic t_fast;
        run_seq(1'b0, 1'b0, 0, 1'b0, 32'h6000_0001, 32'h0000_0000, 32'hFFFF_FFFF);
    endtask

    // extra start while busy (R11)
    task automatic t_start_busy;
        run_seq(1'b1, 1'b1, 2, 1'b1, 32'h0000_0000, 32'h1234_56FF, 32'h0000_0C00);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            cfg_addr[i] = AW'(12'h200 + 2 * i);
            cfg_data[i] = 32'hA500_0000 + DW'(i * 17);
        end
        t_reset();
        t_full();
        t_snoop_nopg();
        t_fast();
        t_start_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule